// File: doc/BRIEF.md
# Table-Loaded Note-Duration Counter

This block times how long one voice of a sound generator keeps sounding. Software writes a duration code into the upper five bits of a length register. The block looks that code up in a fixed, non-linear 32-entry table and loads the 8-bit result into a down-counter. Each half-frame strobe from the frame sequencer then takes one count off, until the counter reaches zero.

A separate control-register write carries a halt flag. While the flag is set, the counter holds its value. The channel enable gates the whole counter: while the channel is off, the counter is held at zero and duration writes are dropped. The `active` output reports whether the counter is nonzero. Other logic uses it to gate the voice and to build a status word.

Top module: `note_len_ctr`

## Requirements
- R1: While `rst_n` is low, `count` is 0 and the held halt flag is 0. Reset is asynchronous and active low.
- R2: When `len_we` is high and `chan_en` is high, the next `count` is TABLE[`len_data[7:3]`]. TABLE, listed by index 0 to 31, is 10, 254, 20, 2, 40, 4, 80, 6, 160, 8, 60, 10, 14, 12, 26, 14, 12, 16, 24, 18, 48, 20, 96, 22, 192, 24, 72, 26, 16, 28, 32, 30. `len_data[2:0]` has no effect.
- R3: On `ctl_we`, the halt flag takes the value of `ctl_data[5]`, and the flag is stored. The other bits of `ctl_data` have no effect.
- R4: When `half_tick` is high, `chan_en` is high, `len_we` is low, the stored halt flag is 0 and `count` is above 0, `count` drops by exactly 1 on the next edge.
- R5: While the stored halt flag is 1, `half_tick` leaves `count` unchanged.
- R6: When `count` is 0, a `half_tick` leaves it at 0. The counter never wraps to 255.
- R7: When `chan_en` is low, the next `count` is 0, whatever `len_we` and `half_tick` do.
- R8: When `len_we` and `half_tick` are high in the same cycle with `chan_en` high, the table value is loaded and is not decremented in that cycle.
- R9: When `ctl_we` and `half_tick` are high in the same cycle, the tick is judged against the halt flag stored before that write.
- R10: `active` is 1 exactly when `count` is nonzero, in the same cycle.
- R11: With no `len_we`, no `half_tick` and `chan_en` high, `count` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control-register write strobe |
| ctl_data | input | 8 | Control write data; bit 5 is the halt flag |
| len_we | input | 1 | Length-register write strobe |
| len_data | input | 8 | Length write data; bits 7:3 index the table |
| chan_en | input | 1 | Channel enable |
| half_tick | input | 1 | Half-frame strobe |
| count | output | 8 | Current duration count |
| active | output | 1 | Count is nonzero |

## Verification
Two functions can land in the same cycle: a duration load and a half-frame decrement. The bench provokes this both in directed steps and in a long random phase in which the strobes overlap often. The expected result is a fresh table value with no decrement applied. A second overlap is a halt-flag write together with a tick. Here the bench model applies the flag that was held before the write, and every cycle it compares `count` and `active` against the model.

// File: rtl/note_len_ctr.sv
module note_len_ctr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_data,
  input  logic       len_we,
  input  logic [7:0] len_data,
  input  logic       chan_en,
  input  logic       half_tick,
  output logic [7:0] count,
  output logic       active
);

  logic       halt_q;
  logic [7:0] load_val;

  always_comb begin
    unique case (len_data[7:3])
      5'd0:  load_val = 8'd10;
      5'd1:  load_val = 8'd254;
      5'd2:  load_val = 8'd20;
      5'd3:  load_val = 8'd2;
      5'd4:  load_val = 8'd40;
      5'd5:  load_val = 8'd4;
      5'd6:  load_val = 8'd80;
      5'd7:  load_val = 8'd6;
      5'd8:  load_val = 8'd160;
      5'd9:  load_val = 8'd8;
      5'd10: load_val = 8'd60;
      5'd11: load_val = 8'd10;
      5'd12: load_val = 8'd14;
      5'd13: load_val = 8'd12;
      5'd14: load_val = 8'd26;
      5'd15: load_val = 8'd14;
      5'd16: load_val = 8'd12;
      5'd17: load_val = 8'd16;
      5'd18: load_val = 8'd24;
      5'd19: load_val = 8'd18;
      5'd20: load_val = 8'd48;
      5'd21: load_val = 8'd20;
      5'd22: load_val = 8'd96;
      5'd23: load_val = 8'd22;
      5'd24: load_val = 8'd192;
      5'd25: load_val = 8'd24;
      5'd26: load_val = 8'd72;
      5'd27: load_val = 8'd26;
      5'd28: load_val = 8'd16;
      5'd29: load_val = 8'd28;
      5'd30: load_val = 8'd32;
      default: load_val = 8'd30;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      halt_q <= 1'b0;
    else if (ctl_we) halt_q <= ctl_data[5];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                  count <= 8'd0;
    else if (!chan_en)                           count <= 8'd0;
    else if (len_we)                             count <= load_val;
    else if (half_tick && !halt_q && count != 0) count <= count - 8'd1;

  assign active = |count;

  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> count == 8'd0); // R7
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && !len_we && halt_q) |=> $stable(count)); // R5
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 8'd0 && !len_we) |=> count == 8'd0); // R6
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && !len_we && half_tick && !halt_q && count != 8'd0) |=> count == $past(count) - 8'd1); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && !len_we && !half_tick) |=> $stable(count)); // R11
  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && len_we) |=> active); // R2

endmodule

// File: tb/tb_note_len_ctr.sv
module tb_note_len_ctr;
  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, len_we = 0, chan_en = 0, half_tick = 0;
  logic [7:0] ctl_data = 0, len_data = 0;
  logic [7:0] count;
  logic active;
  int compared = 0, mismatched = 0;
  bit done = 0;

  int tbl[32] = '{10,254,20,2,40,4,80,6,160,8,60,10,14,12,26,14,
                  12,16,24,18,48,20,96,22,192,24,72,26,16,28,32,30};
  int m_cnt = 0, m_halt = 0;
  string tag = "R1";

  note_len_ctr dut (.clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_data(ctl_data),
    .len_we(len_we), .len_data(len_data), .chan_en(chan_en), .half_tick(half_tick),
    .count(count), .active(active));

  always #5 clk = ~clk;

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_cnt = 0; m_halt = 0; tag = "R1"; end
    else begin
      int old_halt;
      old_halt = m_halt;
      if (ctl_we) m_halt = ctl_data[5];
      if (!chan_en) begin m_cnt = 0; tag = "R7"; end
      else if (len_we) begin m_cnt = tbl[len_data[7:3]]; tag = half_tick ? "R8" : "R2"; end
      else if (half_tick) begin
        if (ctl_we) tag = "R9";
        else if (old_halt != 0) tag = "R5";
        else if (m_cnt == 0) tag = "R6";
        else tag = "R4";
        if (old_halt == 0 && m_cnt > 0) m_cnt = m_cnt - 1;
      end else tag = ctl_we ? "R3" : "R11";
    end
  end

  task automatic check();
    compared++;
    if (count !== m_cnt[7:0]) begin
      mismatched++;
      $display("FAIL %s count actual=%0d expected=%0d", tag, count, m_cnt);
    end
    compared++;
    if (active !== (m_cnt != 0)) begin
      mismatched++;
      $display("FAIL R10 active actual=%0b expected=%0b", active, m_cnt != 0);
    end
  endtask

  task automatic step(input bit e, input bit lw, input int ld, input bit cw, input int cd, input bit t);
    chan_en = e; len_we = lw; len_data = ld[7:0]; ctl_we = cw; ctl_data = cd[7:0]; half_tick = t;
    @(negedge clk);
    check();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check();                                  // R1 reset state
    rst_n = 1;
    step(1, 1, 8'h0F, 0, 0, 0);               // R2 index1 -> 254, low bits ignored
    step(1, 0, 0, 0, 0, 1);                   // R4 -> 253
    step(1, 0, 0, 1, 8'h20, 0);               // R3 halt set
    step(1, 0, 0, 0, 0, 1);                   // R5 hold
    step(1, 0, 0, 1, 8'hDF, 1);               // R9 old halt=1 applies, then cleared
    step(1, 0, 0, 0, 0, 1);                   // R4 other ctl bits ignored (R3)
    step(1, 1, 8'h18, 0, 0, 1);               // R8 index3 -> 2, no decrement
    step(1, 0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 0, 1);                   // reaches 0
    step(1, 0, 0, 0, 0, 1);                   // R6 no wrap
    step(1, 1, 8'hF8, 0, 0, 0);               // R2 index31 -> 30
    step(0, 1, 8'h08, 0, 0, 1);               // R7 forced zero, write ignored
    step(1, 0, 0, 0, 0, 0);                   // R11 stays zero
    for (int i = 0; i < 32; i++) step(1, 1, i << 3, 0, 0, 0);  // R2 full table
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 96, $urandom_range(0, 99) < 4, $urandom_range(0, 255),
           $urandom_range(0, 99) < 5, $urandom_range(0, 255), $urandom_range(0, 99) < 35);
    end
    rst_n = 0;
    #1;
    check();                                  // R1 asynchronous clear
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule